// File: doc/BRIEF.md
# Key-Locked Pin Function Guard

This block keeps one bank of per-pin function-routing bits safe from stray software writes. The protection has two levels. A lock flop must first be opened by writing a 32-bit unlock key. While it is open, software may rewrite a permit mask. The permit mask then decides, bit by bit, which routing bits a write may change. The routing bits drive the pin multiplexers directly through an output port.

Software opens the lock with the key and loads the permit mask. It then writes any non-key value to the key register, which closes the lock again. After that, writes to the routing register can only touch the pins that the permit mask still allows. Reads of every register are combinational and return in the cycle of the read strobe. Offsets that map to no register read as zero, and writes to them are ignored.

Top module: `pin_guard_top`

## Requirements
- R1: After reset the lock is closed (the key register reads 1), the permit mask reads all ones (0xFF for 8 pins) and the routing register reads 0.
- R2: A write of exactly 0x0ACCE551 to the key register (offset 0x520) opens the lock. From the next cycle the key register reads 0.
- R3: A write of any other value to the key register closes the lock. From the next cycle the key register reads 1.
- R4: A write to the permit mask (offset 0x524) while the lock is open stores the low NPIN bits of the write data.
- R5: A write to the permit mask while the lock is closed leaves the mask unchanged. No error is signalled.
- R6: A write to the routing register (offset 0x420) changes only the bits whose permit-mask bit is 1. All other bits keep their value.
- R7: Reads of the permit mask and the routing register return their current values whether the lock is open or closed.
- R8: The route_sel output always equals the routing register value that a read of offset 0x420 returns.
- R9: A read of an unmapped offset returns 0. A write to an unmapped offset changes no register.
- R10: The lock state changes only on writes to the key register and takes effect in the cycle after the write. A permit-mask write in the cycle right after a closing write is therefore ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid while bus_rd is high; 0 otherwise |
| route_sel | output | NPIN | Per-pin function-routing bits |

## Verification
On every cycle the assertions check the following:
- the lock flop follows key writes and holds its value otherwise;
- the permit mask cannot move while the lock is closed;
- no routing bit whose permit bit is clear ever changes;
- reads of the routing register agree with route_sel;
- unmapped reads return zero.

Only the bench scenarios can show the rest. These cover the near-miss key value, the truncation of wide mask writes, and a mask write landing in the cycle right after a closing write. They also cover a partial-mask merge that yields a mix of old and new routing bits, and an unmapped write that must leave all three registers untouched.

// File: rtl/pin_guard_pkg.sv
package pin_guard_pkg;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_KEY    = 2'd1,
        SEL_PERMIT = 2'd2,
        SEL_ROUTE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic locked;
    } key_state_t;

endpackage

// File: rtl/pin_guard_decode.sv
module pin_guard_decode
    import pin_guard_pkg::*;
#(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned KEY_OFS    = 'h520,
    parameter int unsigned PERMIT_OFS = 'h524,
    parameter int unsigned ROUTE_OFS  = 'h420
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_e          sel_o
);
    localparam logic [ADDR_W-1:0] KEY_A    = ADDR_W'(KEY_OFS);
    localparam logic [ADDR_W-1:0] PERMIT_A = ADDR_W'(PERMIT_OFS);
    localparam logic [ADDR_W-1:0] ROUTE_A  = ADDR_W'(ROUTE_OFS);

    always_comb begin
        sel_o = SEL_NONE;
        if (addr_i == KEY_A)         sel_o = SEL_KEY;
        else if (addr_i == PERMIT_A) sel_o = SEL_PERMIT;
        else if (addr_i == ROUTE_A)  sel_o = SEL_ROUTE;
    end
endmodule

// File: rtl/pin_guard_key.sv
module pin_guard_key
    import pin_guard_pkg::*;
#(
    parameter int unsigned DATA_W     = 32,
    parameter logic [31:0] UNLOCK_KEY = 32'h0ACC_E551
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              locked_o
);
    localparam logic [DATA_W-1:0] KEY_W = DATA_W'(UNLOCK_KEY);

    key_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (key_wr_i) st_d.locked = (wdata_i != KEY_W);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{locked: 1'b1};
        else        st_q <= st_d;
    end

    assign locked_o = st_q.locked;

    p_key_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr_i && wdata_i == KEY_W) |=> !locked_o);
    p_key_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr_i && wdata_i != KEY_W) |=> locked_o);
    p_key_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !key_wr_i |=> $stable(locked_o));
endmodule

// File: rtl/pin_guard_bank.sv
module pin_guard_bank #(
    parameter int unsigned NPIN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            permit_wr_i,
    input  logic            route_wr_i,
    input  logic            locked_i,
    input  logic [NPIN-1:0] wdata_i,
    output logic [NPIN-1:0] permit_o,
    output logic [NPIN-1:0] route_o
);
    typedef struct packed {
        logic [NPIN-1:0] permit;
        logic [NPIN-1:0] route;
    } bank_t;

    bank_t           bank_d, bank_q;
    logic [NPIN-1:0] route_nxt;

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        assign route_nxt[g] = (route_wr_i && bank_q.permit[g]) ? wdata_i[g]
                                                               : bank_q.route[g];
    end

    always_comb begin
        bank_d       = bank_q;
        bank_d.route = route_nxt;
        if (permit_wr_i && !locked_i) bank_d.permit = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '{permit: '1, route: '0};
        else        bank_q <= bank_d;
    end

    assign permit_o = bank_q.permit;
    assign route_o  = bank_q.route;

    p_permit_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        locked_i |=> $stable(permit_o));
    p_route_guarded_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((route_o ^ $past(route_o)) & ~$past(permit_o)) == '0));
    p_route_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !route_wr_i |=> $stable(route_o));
endmodule

// File: rtl/pin_guard_top.sv
module pin_guard_top
    import pin_guard_pkg::*;
#(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned NPIN       = 8,
    parameter logic [31:0] UNLOCK_KEY = 32'h0ACC_E551,
    parameter int unsigned KEY_OFS    = 'h520,
    parameter int unsigned PERMIT_OFS = 'h524,
    parameter int unsigned ROUTE_OFS  = 'h420
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NPIN-1:0]   route_sel
);
    reg_sel_e        sel;
    logic            locked;
    logic [NPIN-1:0] permit;
    logic [NPIN-1:0] route;

    pin_guard_decode #(
        .ADDR_W(ADDR_W), .KEY_OFS(KEY_OFS),
        .PERMIT_OFS(PERMIT_OFS), .ROUTE_OFS(ROUTE_OFS)
    ) u_decode (
        .addr_i(bus_addr),
        .sel_o (sel)
    );

    pin_guard_key #(.DATA_W(DATA_W), .UNLOCK_KEY(UNLOCK_KEY)) u_key (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_wr_i(bus_wr && sel == SEL_KEY),
        .wdata_i (bus_wdata),
        .locked_o(locked)
    );

    pin_guard_bank #(.NPIN(NPIN)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .permit_wr_i(bus_wr && sel == SEL_PERMIT),
        .route_wr_i (bus_wr && sel == SEL_ROUTE),
        .locked_i   (locked),
        .wdata_i    (bus_wdata[NPIN-1:0]),
        .permit_o   (permit),
        .route_o    (route)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (sel)
                SEL_KEY:    bus_rdata = DATA_W'(locked);
                SEL_PERMIT: bus_rdata = DATA_W'(permit);
                SEL_ROUTE:  bus_rdata = DATA_W'(route);
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign route_sel = route;

    p_route_mirror_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(ROUTE_OFS)) |-> (bus_rdata[NPIN-1:0] == route_sel));
    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr != ADDR_W'(ROUTE_OFS) && bus_addr != ADDR_W'(PERMIT_OFS)
         && bus_addr != ADDR_W'(KEY_OFS)) |-> (bus_rdata == '0));
endmodule

// File: tb/tb_pin_guard_top.sv
module tb_pin_guard_top;
    localparam int KEYA = 'h520, PERA = 'h524, ROUA = 'h420;
    localparam logic [31:0] KEYV = 32'h0ACC_E551;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  route_sel;

    int checks = 0, failures = 0;
    int m_lock = 1, m_perm = 'hFF, m_route = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pin_guard_top dut (.*);

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int model_read(int a);
        if (a == KEYA) return m_lock;
        if (a == PERA) return m_perm;
        if (a == ROUA) return m_route;
        return 0;
    endfunction

    task automatic step(bit wr, bit rd, int a, logic [31:0] d, string tag);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a[11:0]; bus_wdata = d;
        #1;
        if (rd) check(tag, int'(bus_rdata), model_read(a));
        check({tag, "/R8"}, int'(route_sel), m_route);
        @(posedge clk);
        if (wr) begin
            if (a == KEYA) m_lock = (d != KEYV) ? 1 : 0;
            else if (a == PERA) begin
                if (m_lock == 0) m_perm = int'(d[7:0]);
            end else if (a == ROUA)
                m_route = (m_route & ~m_perm) | (int'(d[7:0]) & m_perm);
        end
    endtask

    task automatic rd(int a, string tag); step(0, 1, a, 0, tag); endtask
    task automatic wr(int a, logic [31:0] d, string tag); step(1, 0, a, d, tag); endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state
        rd(KEYA, "R1"); rd(PERA, "R1"); rd(ROUA, "R1");
        // R6 full mask write
        wr(ROUA, 32'hA5, "R6"); rd(ROUA, "R6");
        // R5 locked permit write ignored
        wr(PERA, 32'h0F, "R5"); rd(PERA, "R5");
        // R3 near-miss key keeps it closed
        wr(KEYA, 32'h0ACC_E550, "R3"); rd(KEYA, "R3");
        // R2 open
        wr(KEYA, KEYV, "R2"); rd(KEYA, "R2");
        // R4 truncated mask store
        wr(PERA, 32'h0000_010F, "R4"); rd(PERA, "R4");
        // R6 partial merge -> 0xAA
        wr(ROUA, 32'h5A, "R6"); rd(ROUA, "R6");
        check("R6 merge", m_route, 'hAA);
        // R3 close with zero, R7 reads while locked
        wr(KEYA, 32'h0, "R3"); rd(KEYA, "R3");
        rd(PERA, "R7"); rd(ROUA, "R7");
        wr(PERA, 32'hFF, "R5"); rd(PERA, "R5");
        // R10 permit write right after closing write
        wr(KEYA, KEYV, "R10"); wr(KEYA, 32'h1234, "R10");
        wr(PERA, 32'hF0, "R10"); rd(PERA, "R10");
        // R9 unmapped
        rd('h100, "R9"); rd('h528, "R9");
        wr('h528, 32'hFF, "R9"); wr('h000, 32'hFF, "R9");
        rd(KEYA, "R9"); rd(PERA, "R9"); rd(ROUA, "R9");
        // R6 zero mask blocks all bits
        wr(KEYA, KEYV, "R6"); wr(PERA, 32'h00, "R6");
        wr(ROUA, 32'h55, "R6"); rd(ROUA, "R6");
        check("R6 blocked", int'(route_sel), 'hAA);
        // R7 reads while open
        rd(PERA, "R7"); rd(KEYA, "R2");
        @(negedge clk); bus_rd = 0; bus_wr = 0;
        done = 1;
    end

    initial begin
        int n = 0;
        while (!done && n < 100000) begin @(posedge clk); n++; end
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=done", n);
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule